// File: doc/BRIEF.md
# Eight-Point Fixed-Point Inverse DCT Core

This block computes one dimension of an 8x8 inverse discrete cosine transform, as used by MPEG-2 style video decoders. Each accepted token carries eight signed 16-bit coefficients and a pass selector. The core splits the work into an even half, which uses coefficients 0, 2, 4 and 6, and an odd half, which uses coefficients 1, 3, 5 and 7. It multiplies by fixed integer cosine weights scaled by 2^11 and merges the two halves in a butterfly. It then drops the fraction with an arithmetic right shift and keeps 16 bits of each result.

A decoder runs the core twice per block. The first run uses row mode over the eight rows, and the second run uses column mode over the transposed intermediate results. The two modes share every multiplier and adder. They differ only in the rounding bias added to coefficient 0 and in the final shift distance. Transpose storage, pixel clamping and memory access belong to the surrounding logic. One token can be accepted every cycle, and results come out after a fixed latency set by a parameter.

Top module: `idct8_core`

## Requirements
- R1: While `rst_n` is low, and after its release until the first result emerges, `valid_out` is 0 and every lane of `pix_out` is 0.
- R2: A token presented with `valid_in`=1 appears with `valid_out`=1 exactly 1+`MID_REG` clock edges later (2 by default). Back-to-back tokens are accepted on every cycle and come out in order.
- R3: With `col_mode`=0 (row pass), 1 is added to f0 before multiplying, and each butterfly result is shifted right arithmetically by 12 (rounding toward minus infinity). With f0=100 and all other coefficients 0, every lane is 50. With f0=-100, every lane is -50.
- R4: With `col_mode`=1 (column pass), 32 is added to f0 and each result is shifted right arithmetically by 17. With f0=100 and all other coefficients 0, every lane is 2.
- R5: The even sums use weights 2048 (f0, f4), 2676 and 1108 (f2, f6):
  - a0 = 2048·f0 + 2048·f4 + 2676·f2 + 1108·f6
  - a3 = 2048·f0 + 2048·f4 − 2676·f2 − 1108·f6
  - a1 = 2048·f0 − 2048·f4 + 1108·f2 − 2676·f6
  - a2 = 2048·f0 − 2048·f4 − 1108·f2 + 2676·f6
- R6: The odd sums use weights 2841, 2408, 1609 and 565:
  - b0 = 2841·f1 + 2408·f3 + 1609·f5 + 565·f7
  - b1 = 2408·f1 − 565·f3 − 2841·f5 − 1609·f7
  - b2 = 1609·f1 − 2841·f3 + 565·f5 + 2408·f7
  - b3 = 565·f1 − 1609·f3 + 2408·f5 − 2841·f7
- R7: Coefficient fi occupies `coef_in[16i+15:16i]`. For k = 0..3, lane k of `pix_out` (bits 16k+15:16k) carries a_k+b_k, and lane 7−k carries a_k−b_k. A token whose coefficients 1..7 are all zero gives eight equal lanes.
- R8: Each lane is the low 16 bits of the shifted 32-bit signed sum. Values outside the 16-bit range wrap and are not clamped.
- R9: While `valid_out` is 0, `pix_out` keeps its last value. `coef_in` and `col_mode` have no effect while `valid_in` is 0.
- R10: The pass selector is captured together with each token's data, so consecutive tokens in alternating modes are each computed in their own mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | A token is present on `coef_in` and `col_mode` |
| col_mode | input | 1 | 0 selects the row pass, 1 selects the column pass |
| coef_in | input | 8*DATA_W | Coefficients f0..f7, with f0 in the lowest lane |
| valid_out | output | 1 | `pix_out` holds a new result |
| pix_out | output | 8*OUT_W | Eight transformed values, lane 0 lowest |

## Verification
The bench builds the core with its default parameters. Those are 16-bit lanes, 32-bit sums, the row bias of 1 with a shift of 12, the column bias of 32 with a shift of 17, and `MID_REG`=1, which registers the sums between the multipliers and the butterfly. This two-stage setting exercises the delay between the sum register and the output register. It shows that the pass selector travels with its token through both stages, and that the output hold survives a token still in flight in the middle stage. Full-scale positive and negative inputs at these widths push the shifted sums past 16 bits, so the wrap of the final truncation is exercised in both directions.

// File: rtl/idct8_pkg.sv
`timescale 1ns/1ps
package idct8_pkg;

   // cosine weights, scaled by 2^11
   localparam int K_C0 = 2048;
   localparam int K_C2 = 2676;
   localparam int K_C4 = 2048;
   localparam int K_C6 = 1108;
   localparam int K_S1 = 2841;
   localparam int K_S3 = 2408;
   localparam int K_S5 = 1609;
   localparam int K_S7 = 565;

   // signed weight applied to odd input j (f1,f3,f5,f7) for odd sum k
   function automatic int odd_weight(input int k, input int j);
      case (k * 4 + j)
         0:  return  K_S1;
         1:  return  K_S3;
         2:  return  K_S5;
         3:  return  K_S7;
         4:  return  K_S3;
         5:  return -K_S7;
         6:  return -K_S1;
         7:  return -K_S5;
         8:  return  K_S5;
         9:  return -K_S1;
         10: return  K_S7;
         11: return  K_S3;
         12: return  K_S7;
         13: return -K_S5;
         14: return  K_S3;
         default: return -K_S1;
      endcase
   endfunction

endpackage

// File: rtl/idct8_even.sv
`timescale 1ns/1ps
// even half: a0..a3 from the biased f0 and f2, f4, f6 (R5)
module idct8_even
   import idct8_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ACC_W  = 32
) (
   input  logic [DATA_W:0]       dc_in,   // f0 with bias already added
   input  logic [3*DATA_W-1:0]   ac_in,   // f2, f4, f6 from low lane up
   output logic [4*ACC_W-1:0]    a_out
);
   localparam logic signed [ACC_W-1:0] C0 = ACC_W'(K_C0);
   localparam logic signed [ACC_W-1:0] C2 = ACC_W'(K_C2);
   localparam logic signed [ACC_W-1:0] C4 = ACC_W'(K_C4);
   localparam logic signed [ACC_W-1:0] C6 = ACC_W'(K_C6);

   logic signed [ACC_W-1:0] x0, x2, x4, x6;
   logic signed [ACC_W-1:0] p_dc, p_q, p_hi, p_lo, s_sum, s_dif;

   assign x0 = ACC_W'($signed(dc_in));
   assign x2 = ACC_W'($signed(ac_in[0*DATA_W +: DATA_W]));
   assign x4 = ACC_W'($signed(ac_in[1*DATA_W +: DATA_W]));
   assign x6 = ACC_W'($signed(ac_in[2*DATA_W +: DATA_W]));

   assign p_dc  = x0 * C0;
   assign p_q   = x4 * C4;
   assign p_hi  = x2 * C2 + x6 * C6;
   assign p_lo  = x2 * C6 - x6 * C2;
   assign s_sum = p_dc + p_q;
   assign s_dif = p_dc - p_q;

   assign a_out[0*ACC_W +: ACC_W] = s_sum + p_hi;
   assign a_out[3*ACC_W +: ACC_W] = s_sum - p_hi;
   assign a_out[1*ACC_W +: ACC_W] = s_dif + p_lo;
   assign a_out[2*ACC_W +: ACC_W] = s_dif - p_lo;

endmodule

// File: rtl/idct8_odd.sv
`timescale 1ns/1ps
// odd half: b0..b3 as a 4x4 weight matrix over f1, f3, f5, f7 (R6)
module idct8_odd
   import idct8_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ACC_W  = 32
) (
   input  logic [4*DATA_W-1:0] odd_in,
   output logic [4*ACC_W-1:0]  b_out
);
   logic signed [ACC_W-1:0] x [4];

   for (genvar j = 0; j < 4; j++) begin : g_ext
      assign x[j] = ACC_W'($signed(odd_in[j*DATA_W +: DATA_W]));
   end

   for (genvar k = 0; k < 4; k++) begin : g_sum
      localparam logic signed [ACC_W-1:0] M0 = ACC_W'(odd_weight(k, 0));
      localparam logic signed [ACC_W-1:0] M1 = ACC_W'(odd_weight(k, 1));
      localparam logic signed [ACC_W-1:0] M2 = ACC_W'(odd_weight(k, 2));
      localparam logic signed [ACC_W-1:0] M3 = ACC_W'(odd_weight(k, 3));
      assign b_out[k*ACC_W +: ACC_W] =
         x[0] * M0 + x[1] * M1 + x[2] * M2 + x[3] * M3;
   end

endmodule

// File: rtl/idct8_bfly.sv
`timescale 1ns/1ps
// butterfly, mode-dependent shift and truncation (R3, R4, R7, R8)
module idct8_bfly #(
   parameter int ACC_W     = 32,
   parameter int OUT_W     = 16,
   parameter int ROW_SHIFT = 12,
   parameter int COL_SHIFT = 17
) (
   input  logic [4*ACC_W-1:0] a_in,
   input  logic [4*ACC_W-1:0] b_in,
   input  logic               col_mode,
   output logic [8*OUT_W-1:0] pix
);
   for (genvar k = 0; k < 4; k++) begin : g_lane
      logic signed [ACC_W-1:0] ak, bk, s_add, s_sub;
      assign ak    = a_in[k*ACC_W +: ACC_W];
      assign bk    = b_in[k*ACC_W +: ACC_W];
      assign s_add = ak + bk;
      assign s_sub = ak - bk;
      assign pix[k*OUT_W +: OUT_W] =
         OUT_W'(col_mode ? (s_add >>> COL_SHIFT) : (s_add >>> ROW_SHIFT));
      assign pix[(7-k)*OUT_W +: OUT_W] =
         OUT_W'(col_mode ? (s_sub >>> COL_SHIFT) : (s_sub >>> ROW_SHIFT));
   end

endmodule

// File: rtl/idct8_core.sv
`timescale 1ns/1ps
module idct8_core #(
   parameter int DATA_W    = 16,
   parameter int ACC_W     = 32,
   parameter int OUT_W     = 16,
   parameter int ROW_BIAS  = 1,
   parameter int COL_BIAS  = 32,
   parameter int ROW_SHIFT = 12,
   parameter int COL_SHIFT = 17,
   parameter int MID_REG   = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid_in,
   input  logic                col_mode,
   input  logic [8*DATA_W-1:0] coef_in,
   output logic                valid_out,
   output logic [8*OUT_W-1:0]  pix_out
);
   localparam int SUM_W = 4 * ACC_W;

   // elaboration-time parameter checks
   if (ACC_W < DATA_W + 16) begin : g_bad_acc
      $error("idct8_core: ACC_W too narrow for DATA_W");
   end
   if (ROW_SHIFT >= ACC_W || COL_SHIFT >= ACC_W) begin : g_bad_shift
      $error("idct8_core: shift distance must be below ACC_W");
   end
   if (OUT_W > ACC_W) begin : g_bad_out
      $error("idct8_core: OUT_W exceeds ACC_W");
   end
   if (MID_REG != 0 && MID_REG != 1) begin : g_bad_mid
      $error("idct8_core: MID_REG must be 0 or 1");
   end

   // mode-dependent bias on f0 (R3, R4)
   logic [DATA_W:0]        dc_biased;
   logic [3*DATA_W-1:0]    even_ac;
   logic [4*DATA_W-1:0]    odd_co;
   logic [SUM_W-1:0]       a_c, b_c;

   assign dc_biased = (DATA_W+1)'($signed(coef_in[DATA_W-1:0]))
                    + (col_mode ? (DATA_W+1)'(COL_BIAS) : (DATA_W+1)'(ROW_BIAS));

   for (genvar j = 0; j < 3; j++) begin : g_even_pick
      assign even_ac[j*DATA_W +: DATA_W] = coef_in[(2*j+2)*DATA_W +: DATA_W];
   end
   for (genvar j = 0; j < 4; j++) begin : g_odd_pick
      assign odd_co[j*DATA_W +: DATA_W] = coef_in[(2*j+1)*DATA_W +: DATA_W];
   end

   idct8_even #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_even (
      .dc_in (dc_biased),
      .ac_in (even_ac),
      .a_out (a_c)
   );

   idct8_odd #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_odd (
      .odd_in (odd_co),
      .b_out  (b_c)
   );

   // optional register between sums and butterfly (R2, R10)
   logic             stg_v, stg_m;
   logic [SUM_W-1:0] stg_a, stg_b;

   if (MID_REG == 1) begin : g_mid
      logic             v_q, m_q;
      logic [SUM_W-1:0] a_q, b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            m_q <= 1'b0;
            a_q <= '0;
            b_q <= '0;
         end else begin
            v_q <= valid_in;
            if (valid_in) begin
               m_q <= col_mode;
               a_q <= a_c;
               b_q <= b_c;
            end
         end
      end
      assign stg_v = v_q;
      assign stg_m = m_q;
      assign stg_a = a_q;
      assign stg_b = b_q;
   end else begin : g_direct
      assign stg_v = valid_in;
      assign stg_m = col_mode;
      assign stg_a = a_c;
      assign stg_b = b_c;
   end

   logic [8*OUT_W-1:0] pix_c;

   idct8_bfly #(
      .ACC_W     (ACC_W),
      .OUT_W     (OUT_W),
      .ROW_SHIFT (ROW_SHIFT),
      .COL_SHIFT (COL_SHIFT)
   ) i_bfly (
      .a_in     (stg_a),
      .b_in     (stg_b),
      .col_mode (stg_m),
      .pix      (pix_c)
   );

   // output register, loads only with a token (R1, R9)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_out <= 1'b0;
         pix_out   <= '0;
      end else begin
         valid_out <= stg_v;
         if (stg_v) pix_out <= pix_c;
      end
   end

endmodule

// File: rtl/idct8_core_chk.sv
`timescale 1ns/1ps
module idct8_core_chk #(
   parameter int DATA_W = 16,
   parameter int OUT_W  = 16,
   parameter int LAT    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                valid_in,
   input logic [7*DATA_W-1:0] ac_coefs,
   input logic                valid_out,
   input logic [8*OUT_W-1:0]  pix_out
);
   logic [LAT-1:0] v_sh, dc_sh;
   logic           lanes_same;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_sh  <= '0;
         dc_sh <= '0;
      end else begin
         v_sh[0]  <= valid_in;
         dc_sh[0] <= (ac_coefs == '0);
         for (int i = 1; i < LAT; i++) begin
            v_sh[i]  <= v_sh[i-1];
            dc_sh[i] <= dc_sh[i-1];
         end
      end
   end

   always_comb begin
      lanes_same = 1'b1;
      for (int k = 1; k < 8; k++)
         if (pix_out[k*OUT_W +: OUT_W] != pix_out[OUT_W-1:0]) lanes_same = 1'b0;
   end

   a_r1_reset_idle: assert property (@(posedge clk) !rst_n |-> !valid_out);

   a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      valid_out == v_sh[LAT-1]);

   a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_out |-> $stable(pix_out));

   a_r7_dc_lanes_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && dc_sh[LAT-1]) |-> lanes_same);

endmodule

bind idct8_core idct8_core_chk #(
   .DATA_W (DATA_W),
   .OUT_W  (OUT_W),
   .LAT    (1 + MID_REG)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_in  (valid_in),
   .ac_coefs  (coef_in[8*DATA_W-1:DATA_W]),
   .valid_out (valid_out),
   .pix_out   (pix_out)
);

// File: tb/test_idct8_core.sv
`timescale 1ns/1ps
module test_idct8_core;
   localparam int DW  = 16;
   localparam int MID = 1;
   localparam int LAT = 1 + MID;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           valid_in = 1'b0;
   logic           col_mode = 1'b0;
   logic [8*DW-1:0] coef_in = '0;
   logic           valid_out;
   logic [8*DW-1:0] pix_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [8*DW-1:0] qexp[$];
   string           qtag[$];
   logic [7:0]      vhist = '0;

   always #4 clk = ~clk;

   idct8_core #(.MID_REG(MID)) i_idct8_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_in  (valid_in),
      .col_mode  (col_mode),
      .coef_in   (coef_in),
      .valid_out (valid_out),
      .pix_out   (pix_out)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [8*DW-1:0] act, input logic [8*DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [8*DW-1:0] ref_idct(input logic [8*DW-1:0] c, input bit col);
      longint f[8];
      longint a[4];
      longint b[4];
      longint s;
      int sh;
      logic [8*DW-1:0] r;
      for (int i = 0; i < 8; i++) f[i] = longint'($signed(c[DW*i +: DW]));
      f[0] += col ? 32 : 1;
      sh = col ? 17 : 12;
      a[0] = 2048*f[0] + 2048*f[4] + 2676*f[2] + 1108*f[6];
      a[3] = 2048*f[0] + 2048*f[4] - 2676*f[2] - 1108*f[6];
      a[1] = 2048*f[0] - 2048*f[4] + 1108*f[2] - 2676*f[6];
      a[2] = 2048*f[0] - 2048*f[4] - 1108*f[2] + 2676*f[6];
      b[0] = 2841*f[1] + 2408*f[3] + 1609*f[5] +  565*f[7];
      b[1] = 2408*f[1] -  565*f[3] - 2841*f[5] - 1609*f[7];
      b[2] = 1609*f[1] - 2841*f[3] +  565*f[5] + 2408*f[7];
      b[3] =  565*f[1] - 1609*f[3] + 2408*f[5] - 2841*f[7];
      for (int k = 0; k < 4; k++) begin
         s = (a[k] + b[k]) >>> sh;
         r[DW*k +: DW] = s[15:0];
         s = (a[k] - b[k]) >>> sh;
         r[DW*(7-k) +: DW] = s[15:0];
      end
      return r;
   endfunction

   // monitor: samples 2 ns after each rising edge
   always @(posedge clk) begin
      logic [8*DW-1:0] e;
      string t;
      #2;
      if (!rst_n) vhist = '0;
      else begin
         vhist = {vhist[6:0], valid_in};
         check(valid_out == vhist[LAT-1], "R2", "valid_out timing",
               {127'd0, valid_out}, {127'd0, vhist[LAT-1]});
         if (valid_out) begin
            if (qexp.size() == 0)
               check(1'b0, "R2", "token without request", pix_out, '0);
            else begin
               e = qexp.pop_front();
               t = qtag.pop_front();
               check(pix_out == e, t, "pix_out", pix_out, e);
            end
         end
      end
   end

   task automatic send(input logic [8*DW-1:0] c, input bit col, input string tag,
                       input bit use_exp, input logic [8*DW-1:0] exp);
      @(negedge clk);
      valid_in = 1'b1;
      col_mode = col;
      coef_in  = c;
      qexp.push_back(use_exp ? exp : ref_idct(c, col));
      qtag.push_back(tag);
   endtask

   task automatic drain();
      @(negedge clk);
      valid_in = 1'b0;
      while (qexp.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   function automatic logic [8*DW-1:0] lane(input int idx, input int val);
      logic [8*DW-1:0] r = '0;
      r[DW*idx +: DW] = DW'(val);
      return r;
   endfunction

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(valid_out == 1'b0 && pix_out == '0, "R1", "during reset", pix_out, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(valid_out == 1'b0 && pix_out == '0, "R1", "after release", pix_out, '0);
   endtask

   task automatic t_dc();
      send(lane(0, 100),  1'b0, "R3 R7 row dc",     1'b1, {8{16'd50}});
      send(lane(0, 100),  1'b1, "R4 R7 col dc",     1'b1, {8{16'd2}});
      send(lane(0, -100), 1'b0, "R3 negative floor", 1'b1, {8{16'hFFCE}});
      drain();
   endtask

   task automatic t_even();
      for (int m = 0; m < 2; m++)
         for (int i = 2; i < 8; i += 2)
            send(lane(i, 1000) | lane(0, -37), m[0], "R5 even impulse", 1'b0, '0);
      drain();
   endtask

   task automatic t_odd();
      for (int m = 0; m < 2; m++)
         for (int i = 1; i < 8; i += 2)
            send(lane(i, -1500), m[0], "R6 odd impulse", 1'b0, '0);
      drain();
   endtask

   task automatic t_order();
      logic [8*DW-1:0] c;
      for (int i = 0; i < 8; i++) c[DW*i +: DW] = DW'((i + 1) * 311 - 1200);
      send(c, 1'b0, "R7 lane order row", 1'b0, '0);
      send(c, 1'b1, "R7 lane order col", 1'b0, '0);
      drain();
   endtask

   task automatic t_wrap();
      send({8{16'h7FFF}}, 1'b0, "R8 wrap positive", 1'b0, '0);
      send({8{16'h8000}}, 1'b0, "R8 wrap negative", 1'b0, '0);
      send({16'h0, 16'h7FFF, 16'h0, 16'h7FFF, 16'h0, 16'h7FFF, 16'h0, 16'h7FFF},
           1'b0, "R8 wrap even", 1'b0, '0);
      drain();
   endtask

   task automatic t_stream();
      logic [8*DW-1:0] c;
      for (int n = 0; n < 10; n++) begin
         for (int i = 0; i < 8; i++) c[DW*i +: DW] = DW'((n * 8 + i) * 1237 - 21000);
         send(c, n[0], "R10 alternating stream", 1'b0, '0);
      end
      drain();
   endtask

   task automatic t_hold();
      logic [8*DW-1:0] keep;
      send(lane(3, 4000), 1'b1, "R9 token before hold", 1'b0, '0);
      drain();
      keep = pix_out;
      for (int n = 0; n < 6; n++) begin
         @(negedge clk);
         check(pix_out == keep && valid_out == 1'b0, "R9", "idle hold", pix_out, keep);
         valid_in = 1'b0;
         col_mode = ~col_mode;
         coef_in  = {8{DW'(n * 9001 + 5)}};
      end
      @(negedge clk);
      check(pix_out == keep, "R9", "idle hold end", pix_out, keep);
   endtask

   initial begin
      t_reset();
      t_dc();
      t_even();
      t_odd();
      t_order();
      t_wrap();
      t_stream();
      t_hold();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 50000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule